// File: doc/BRIEF.md
# MDIO Management Master with Selectable Clock Divider

This block runs management read and write cycles to PHY registers over a two-wire MDC/MDIO link. Software programs a 32-bit control register with a PHY address, a register index, a clock-ratio code and a direction flag. It starts a cycle by writing that register with the busy bit set. A 16-bit data register supplies the payload for a write and receives the returned value of a read.

While a cycle runs, the block derives MDC from the system clock with one of four fixed ratios. It shifts out a complete 64-bit management frame, MSB first. For a read, it releases the data line and captures the PHY's reply. When the frame ends, busy drops and the register contents can be read back.

The data line is presented as a split pad control: an output value, an output enable and a sampled input. These are meant to be joined at a tri-state pad with a pull-up.

Top module: `mdio_master`

## Requirements
- R1: The control register resets to zero and reads back as {16'b0, phy[15:11], reg[10:6], csel[5:2], wr[1], busy[0]}. Bits 31:16 always read zero. The data register reads back as {16'b0, data[15:0]}. The read port selects data when `rd_sel`=1 and control when `rd_sel`=0.
- R2: A control write with bit 0 set, made while idle, starts a frame. Busy reads 1 from the next cycle until the final MDC falling edge of the frame, then reads 0.
- R3: While busy, writes to the control register and to the data register are ignored. Register contents and the frame in flight are unchanged.
- R4: MDC runs at system clock / 42, / 62, / 16 or / 26 for csel codes 0, 1, 2 and 3. The high and low halves are equal. The first half after the start is low.
- R5: csel codes 4 to 15 behave as code 0 (divide by 42). The programmed code still reads back unchanged.
- R6: A frame is 64 bits, MSB first. It carries 32 ones, start bits 01, an opcode (10 for a read, 01 for a write), a 5-bit PHY address, a 5-bit register index, a 2-bit turnaround and 16 data bits. Bit n is presented during MDC period n.
- R7: In a write, MDIO is driven for all 64 bits. The turnaround is 10 and the data bits are the data register's contents.
- R8: In a read, MDIO is driven for bits 0 to 45 and released for bits 46 to 63. Bits 48 to 63 are sampled on MDC rising edges and stored MSB first into the data register when the frame ends.
- R9: During a frame, the MDIO value and enable change only on the cycle in which MDC falls.
- R10: Every PHY address from 0 to 31 is emitted unchanged. This includes 0, which addresses the integrated PHY, and 31.
- R11: When no frame is active, MDC is low and MDIO is released. A control write without bit 0 set starts no MDC activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 32 | Register write value |
| rd_sel | input | 1 | Read source: 0 control, 1 data |
| rd_data | output | 32 | Register read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to the pad |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
The assertions assume that software writes each register at most once per cycle. They also assume that the clock-select field is never altered except through a control write made while idle. The register guard enforces this, so the MDC half-length check may read the stored code. The stimulus writes registers only between frames, apart from one deliberate write to each register during every frame. It drives the MDIO input only in step with the falling edge of the modelled MDC, so every sampled bit is settled well before a rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DAT_POS   = TA_POS + 2;
  localparam int BIT_W     = $clog2(FRAME_LEN + 1);
  localparam int HALF_W    = 6;
  localparam int BUS_W     = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] reg_idx;
    logic [3:0]        csel;
    logic              wr;
    logic              busy;
  } ctrl_t;

  function automatic logic [HALF_W-1:0] half_period(input logic [3:0] code);
    case (code)
      4'd1:    half_period = HALF_W'(31);
      4'd2:    half_period = HALF_W'(8);
      4'd3:    half_period = HALF_W'(13);
      default: half_period = HALF_W'(21);
    endcase
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_sel,
  input  logic              done,
  input  logic [DATA_W-1:0] cap_data,
  output logic [BUS_W-1:0]  rd_data,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] data_q,
  output logic              start
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_d;
  logic [DATA_W-1:0] data_d;
  logic              ctrl_we;
  logic              data_we;
  logic              unused_hi;

  assign unused_hi = ^wr_data[BUS_W-1:CTRL_W];
  assign ctrl_we   = wr_en && !wr_sel && !ctrl_q.busy;
  assign data_we   = wr_en &&  wr_sel && !ctrl_q.busy;
  assign start     = ctrl_we && wr_data[0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we)   ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    else if (done) ctrl_d.busy = 1'b0;
  end

  always_comb begin
    data_d = data_q;
    if (data_we)                  data_d = wr_data[DATA_W-1:0];
    else if (done && !ctrl_q.wr)  data_d = cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    if (rd_sel) rd_data = {{(BUS_W-DATA_W){1'b0}}, data_q};
    else        rd_data = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
  end
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] csel,
  output logic       mdc,
  output logic       rise,
  output logic       fall
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              mdc_q, mdc_d;
  logic [HALF_W-1:0] half;
  logic              tick;

  assign half = half_period(csel);
  assign tick = run && (cnt_q == half - HALF_W'(1));
  assign rise = tick && !mdc_q;
  assign fall = tick &&  mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
      mdc_d = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 is_read,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    cap_data
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);
  localparam logic [BIT_W-1:0] TA_BIT   = BIT_W'(TA_POS);
  localparam logic [BIT_W-1:0] DAT_BIT  = BIT_W'(DAT_POS);

  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic                 act_q, act_d;
  logic                 rd_q, rd_d;
  logic [DATA_W-1:0]    cap_q, cap_d;

  assign done     = act_q && fall && (bit_q == LAST_BIT);
  assign active   = act_q;
  assign mdio_o   = act_q && sh_q[FRAME_LEN-1];
  assign mdio_oe  = act_q && !(rd_q && (bit_q >= TA_BIT));
  assign cap_data = cap_q;

  always_comb begin
    sh_d  = sh_q;
    bit_d = bit_q;
    act_d = act_q;
    rd_d  = rd_q;
    cap_d = cap_q;
    if (start) begin
      sh_d  = frame;
      bit_d = '0;
      act_d = 1'b1;
      rd_d  = is_read;
    end else if (act_q) begin
      if (rise && rd_q && (bit_q >= DAT_BIT))
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (bit_q == LAST_BIT) begin
          act_d = 1'b0;
        end else begin
          bit_d = bit_q + BIT_W'(1);
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
      act_q <= act_d;
      rd_q  <= rd_d;
      cap_q <= cap_d;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [BUS_W-1:0] rd_data,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [1:0]           rst_sync_q;
  logic                 rst_n_s;
  ctrl_t                ctrl_q;
  ctrl_t                new_ctrl;
  logic [DATA_W-1:0]    data_q;
  logic [DATA_W-1:0]    cap_data;
  logic                 start;
  logic                 done;
  logic                 active;
  logic                 rise;
  logic                 fall;
  logic [FRAME_LEN-1:0] frame;

  // reset asserts at once and is released two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign new_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);

  // frame assembled from the incoming control word, so it is ready on the start edge
  always_comb begin
    frame = {{PRE_LEN{1'b1}}, 2'b01,
             (new_ctrl.wr ? 2'b01 : 2'b10),
             new_ctrl.phy, new_ctrl.reg_idx,
             (new_ctrl.wr ? 2'b10 : 2'b11),
             (new_ctrl.wr ? data_q : {DATA_W{1'b1}})};
  end

  mdio_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .done     (done),
    .cap_data (cap_data),
    .rd_data  (rd_data),
    .ctrl_q   (ctrl_q),
    .data_q   (data_q),
    .start    (start)
  );

  mdio_clkgen u_clkgen (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (active),
    .csel  (ctrl_q.csel),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mdio_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .frame    (frame),
    .is_read  (!new_ctrl.wr),
    .rise     (rise),
    .fall     (fall),
    .mdio_i   (mdio_i),
    .active   (active),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .cap_data (cap_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  mdc,
  input logic  mdio_o,
  input logic  mdio_oe,
  input ctrl_t ctrl
);
  logic [7:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_len <= '0;
    else if (mdc) hi_len <= hi_len + 8'd1;
    else          hi_len <= '0;
  end

  // R11: quiet link outside a frame
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.busy |-> (!mdc && !mdio_oe));

  // R9: data line moves only with a falling MDC
  p_mdio_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.busy && $past(ctrl.busy) && !$stable({mdio_o, mdio_oe})) |-> $fell(mdc));

  // R3: control register frozen while busy
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.busy && $past(ctrl.busy)) |-> $stable(ctrl));

  // R4 and R5: high half matches the selected ratio
  p_mdc_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_len == {2'b00, half_period(ctrl.csel)}));

  // R2: busy ends together with the last MDC falling edge
  p_busy_ends_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.busy) |-> $fell(mdc));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .ctrl    (ctrl_q)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic        rd_sel;
  logic [31:0] rd_data;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int n_cmp;
  int n_bad;
  int cyc;
  bit finished;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int bench_half(input int code);
    int ratio;
    if (code == 1)      ratio = 62;
    else if (code == 2) ratio = 16;
    else if (code == 3) ratio = 26;
    else                ratio = 42;
    return ratio / 2;
  endfunction

  task automatic reg_write(input bit sel, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input bit sel, output logic [31:0] val);
    @(negedge clk);
    rd_sel = sel;
    #1 val = rd_data;
    rd_sel = 1'b0;
  endtask

  // one complete frame against the behavioural model
  task automatic run_frame(input int phy, input int ridx, input int csel, input bit wr,
                           input logic [15:0] wdat, input logic [15:0] resp);
    logic [63:0] exp_frame;
    logic [31:0] ctrl_word;
    logic [31:0] rv;
    int h;
    int halves;
    int b;
    bit e_mdc, e_busy, e_oe;

    if (wr) reg_write(1'b1, {16'hDEAD, wdat});
    h = bench_half(csel);
    exp_frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy[4:0], ridx[4:0],
                 (wr ? 2'b10 : 2'b00), (wr ? wdat : 16'h0000)};
    ctrl_word = {16'h0, phy[4:0], ridx[4:0], csel[3:0], wr, 1'b1};

    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = ctrl_word;
    @(posedge clk);
    for (int k = 0; k <= 128 * h; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (k == 5 * h) begin
        // R3: attempts to disturb the frame in flight
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = ~ctrl_word;
      end
      if (k == 7 * h) begin
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0000_1234;
      end
      halves = k / h;
      b      = halves / 2;
      e_busy = (k < 128 * h);
      e_mdc  = e_busy && (halves % 2 == 1);
      e_oe   = e_busy && (wr || b < 46);
      #1;
      chk("R4 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk("R2 busy", {31'b0, rd_data[0]}, {31'b0, e_busy});
      chk(wr ? "R7 oe" : "R8 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe)
        chk(b < 36 ? "R6 bit" : (b < 41 ? "R10 addr" : "R7 bit"),
            {31'b0, mdio_o}, {31'b0, exp_frame[63 - b]});
      mdio_i = (e_busy && !wr && b >= 48) ? resp[63 - b] : 1'b1;
    end
    @(negedge clk);
    wr_en = 1'b0;
    mdio_i = 1'b1;
    reg_read(1'b0, rv);
    chk("R3 ctrl after frame", rv, {ctrl_word[31:1], 1'b0});
    reg_read(1'b1, rv);
    chk(wr ? "R3 data kept" : "R8 read data", rv, {16'h0, wr ? wdat : resp});
  endtask

  initial begin
    logic [31:0] rv;
    n_cmp = 0; n_bad = 0; cyc = 0; finished = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0; mdio_i = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    reg_read(1'b0, rv); chk("R1 ctrl reset", rv, 32'h0);
    reg_read(1'b1, rv); chk("R1 data reset", rv, 32'h0);
    chk("R11 mdc idle", {31'b0, mdc}, 32'h0);
    chk("R11 oe idle", {31'b0, mdio_oe}, 32'h0);

    // R1 and R11: write without busy bit, reserved bits read zero, no activity
    reg_write(1'b0, 32'hFFFF_FFFE);
    reg_read(1'b0, rv); chk("R1 ctrl readback", rv, 32'h0000_FFFE);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R11 no start", {30'b0, mdc, mdio_oe}, 32'h0);
    end

    run_frame(5, 17, 2, 1'b1, 16'hA5C3, 16'h0000);   // R7, R4 /16
    run_frame(0, 2, 3, 1'b0, 16'h0000, 16'h1D2B);    // R8, R10 addr 0, /26
    run_frame(31, 31, 1, 1'b0, 16'h0000, 16'hF00F);  // R10 addr 31, /62
    run_frame(31, 0, 0, 1'b1, 16'h8001, 16'h0000);   // R6, /42
    run_frame(10, 3, 9, 1'b0, 16'h0000, 16'h5AA5);   // R5 reserved code
    run_frame(1, 1, 15, 1'b1, 16'h7FFE, 16'h0000);   // R5 reserved code

    // R5: reserved code reads back unchanged
    reg_read(1'b0, rv); chk("R5 code readback", rv[5:2], 32'd15);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule